// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block decides whether a memory access may proceed once a translation entry for its address has been found. It reads the entry's domain number, mapping kind and permission bits, together with the virtual address, the direction of the access, the processor mode, two protection control bits (system and ROM) and the domain access control word. From these it produces a two-bit fault code and a copy of the entry's domain number. Both outputs are registered, so the result for a set of inputs presented at one clock edge is visible after that edge.

The domain access control word holds one two-bit access value per domain. A domain that has no access, or the reserved value, faults at once. A manager domain passes without any permission check. A client domain has its access checked against a two-bit permission code. That code is picked out of the entry's permission bits by a subpage index, and the index comes from virtual address bits that depend on the mapping kind.

Top module: `dom_perm_check`

## Requirements
- R1: While `rst` is high at a rising clock edge, `fault_o` becomes 0 and `last_dom_o` becomes 0 after that edge.
- R2: The access value for domain d is `dacr_i[2*d+1:2*d]`. The values 0 and 2 give fault code 1 (domain fault).
- R3: Access value 3 (manager) gives fault code 0, whatever the permission code, mode, direction and control bits are.
- R4: Access value 1 (client) gives fault code 0 when the selected permission code allows the access, and a permission fault when it does not.
- R5: Mapping codes: 0 invalid, 1 small page, 2 large page, 3 section, 4 extended small page, 5 tiny page. The subpage index is `va_i[11:10]` for small pages and `va_i[15:14]` for large pages.
- R6: The subpage index is fixed at 3 for sections and at 0 for tiny pages, extended small pages and invalid entries. The permission code is `perm_i[2*idx+5:2*idx+4]`.
- R7: Permission code 0 allows reads only, and only when the mode is privileged with `sys_i` high, or when `rom_i` is high. Code 1 allows privileged accesses only. Code 2 allows every read and privileged writes. Code 3 allows every access.
- R8: Mode values 5'h10 (user) and 5'h1F (system) are unprivileged. Every other mode value is privileged.
- R9: A permission fault is code 2 for a section mapping and code 3 for every other mapping.
- R10: Outside reset, `fault_o` and `last_dom_o` reflect the inputs sampled at the previous rising edge. `last_dom_o` equals that sampled `dom_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dom_i | input | 4 | Domain number of the translation entry |
| map_i | input | 3 | Mapping kind of the entry (codes in R5) |
| perm_i | input | 12 | Permission bits of the entry |
| va_i | input | 32 | Virtual address of the access |
| rd_i | input | 1 | 1 for a read, 0 for a write |
| mode_i | input | 5 | Processor mode value |
| sys_i | input | 1 | System protection control bit |
| rom_i | input | 1 | ROM protection control bit |
| dacr_i | input | 32 | Domain access control word, two bits per domain |
| fault_o | output | 2 | 0 none, 1 domain, 2 section permission, 3 subpage permission |
| last_dom_o | output | 4 | Registered copy of the entry's domain |

## Verification
The hardest case to reach from the ports is a design that reads the wrong permission slot or the wrong domain field and still happens to give the right answer. The sweep therefore loads the unselected permission slots with a code whose outcome differs from that of the selected slot, and the unselected domain fields with a different access value. It also drives the small-page and large-page index fields of the address with different values, so that decoding the wrong field changes the fault code. Every mapping kind, subpage, permission code, direction, mode class, control bit pair and access value is crossed, and the domain number moves through all sixteen values as the sweep runs.

// File: rtl/dom_perm_pkg.sv
package dom_perm_pkg;

  typedef enum logic [2:0] {
    MAP_INVALID = 3'd0,
    MAP_SMALL   = 3'd1,
    MAP_LARGE   = 3'd2,
    MAP_SECTION = 3'd3,
    MAP_ESMALL  = 3'd4,
    MAP_TINY    = 3'd5
  } map_kind_t;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_DOMAIN   = 2'd1,
    FLT_SEC_PERM = 2'd2,
    FLT_SUB_PERM = 2'd3
  } fault_t;

  localparam logic [4:0] MODE_USER   = 5'h10;
  localparam logic [4:0] MODE_SYSTEM = 5'h1F;

  localparam logic [1:0] ACC_NONE    = 2'd0;
  localparam logic [1:0] ACC_CLIENT  = 2'd1;
  localparam logic [1:0] ACC_RESV    = 2'd2;
  localparam logic [1:0] ACC_MANAGER = 2'd3;

endpackage

// File: rtl/dom_perm_dom_sel.sv
module dom_perm_dom_sel #(
  parameter int DOM_W = 4,
  localparam int NDOM = 1 << DOM_W
) (
  input  logic [DOM_W-1:0]  dom_i,
  input  logic [2*NDOM-1:0] dacr_i,
  output logic [1:0]        acc_o
);
  logic [1:0] fld [NDOM];

  for (genvar g = 0; g < NDOM; g++) begin : g_fld
    assign fld[g] = dacr_i[2*g +: 2];
  end

  assign acc_o = fld[dom_i];
endmodule

// File: rtl/dom_perm_ap_sel.sv
module dom_perm_ap_sel
  import dom_perm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PERM_W = 12,
  parameter int SMALL_LSB = 10,
  parameter int LARGE_LSB = 14
) (
  input  logic [2:0]        map_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [PERM_W-1:0] perm_i,
  output logic [1:0]        ap_o
);
  logic [1:0] idx;
  logic [7:0] slots;
  logic       unused_va;
  logic       unused_perm;

  assign unused_va   = ^{va_i[ADDR_W-1:LARGE_LSB+2], va_i[LARGE_LSB-1:SMALL_LSB+2],
                         va_i[SMALL_LSB-1:0]};
  assign slots       = perm_i[4 +: 8];
  assign unused_perm = ^{perm_i[PERM_W-1:12], perm_i[3:0]};

  always_comb begin
    unique case (map_kind_t'(map_i))
      MAP_SMALL:   idx = va_i[SMALL_LSB +: 2];
      MAP_LARGE:   idx = va_i[LARGE_LSB +: 2];
      MAP_SECTION: idx = 2'd3;
      default:     idx = 2'd0;
    endcase
  end

  always_comb begin
    unique case (idx)
      2'd0: ap_o = slots[1:0];
      2'd1: ap_o = slots[3:2];
      2'd2: ap_o = slots[5:4];
      default: ap_o = slots[7:6];
    endcase
  end
endmodule

// File: rtl/dom_perm_ap_eval.sv
module dom_perm_ap_eval
  import dom_perm_pkg::*;
(
  input  logic [1:0] ap_i,
  input  logic [4:0] mode_i,
  input  logic       rd_i,
  input  logic       sys_i,
  input  logic       rom_i,
  output logic       ok_o
);
  logic unpriv;

  assign unpriv = (mode_i == MODE_USER) || (mode_i == MODE_SYSTEM);

  always_comb begin
    unique case (ap_i)
      2'd0:    ok_o = rd_i && ((sys_i && !unpriv) || rom_i);
      2'd1:    ok_o = !unpriv;
      2'd2:    ok_o = rd_i || !unpriv;
      default: ok_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dom_perm_check.sv
module dom_perm_check
  import dom_perm_pkg::*;
#(
  parameter int DOM_W  = 4,
  parameter int ADDR_W = 32,
  parameter int PERM_W = 12,
  localparam int DACR_W = 2 * (1 << DOM_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DOM_W-1:0]  dom_i,
  input  logic [2:0]        map_i,
  input  logic [PERM_W-1:0] perm_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic              rd_i,
  input  logic [4:0]        mode_i,
  input  logic              sys_i,
  input  logic              rom_i,
  input  logic [DACR_W-1:0] dacr_i,
  output logic [1:0]        fault_o,
  output logic [DOM_W-1:0]  last_dom_o
);
  logic [1:0] acc;
  logic [1:0] ap;
  logic       ok;
  fault_t     nxt;

  dom_perm_dom_sel #(.DOM_W(DOM_W)) u_dom (
    .dom_i(dom_i), .dacr_i(dacr_i), .acc_o(acc)
  );

  dom_perm_ap_sel #(.ADDR_W(ADDR_W), .PERM_W(PERM_W)) u_ap (
    .map_i(map_i), .va_i(va_i), .perm_i(perm_i), .ap_o(ap)
  );

  dom_perm_ap_eval u_eval (
    .ap_i(ap), .mode_i(mode_i), .rd_i(rd_i), .sys_i(sys_i), .rom_i(rom_i), .ok_o(ok)
  );

  always_comb begin
    unique case (acc)
      ACC_MANAGER: nxt = FLT_NONE;
      ACC_CLIENT: begin
        if (ok)                   nxt = FLT_NONE;
        else if (map_i == MAP_SECTION) nxt = FLT_SEC_PERM;
        else                      nxt = FLT_SUB_PERM;
      end
      default:     nxt = FLT_DOMAIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_o    <= FLT_NONE;
      last_dom_o <= '0;
    end else begin
      fault_o    <= nxt;
      last_dom_o <= dom_i;
    end
  end
endmodule

// File: rtl/dom_perm_check_sva.sv
module dom_perm_check_sva #(
  parameter int DOM_W = 4,
  localparam int DACR_W = 2 * (1 << DOM_W)
) (
  input logic              clk,
  input logic              rst,
  input logic [DOM_W-1:0]  dom_i,
  input logic [2:0]        map_i,
  input logic [DACR_W-1:0] dacr_i,
  input logic [1:0]        fault_o,
  input logic [DOM_W-1:0]  last_dom_o
);
  logic [1:0] acc;
  assign acc = dacr_i[{dom_i, 1'b0} +: 2];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (fault_o == 2'd0 && last_dom_o == '0));

  // R2
  domain_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == 2'd0 || acc == 2'd2) |=> fault_o == 2'd1);

  // R3
  manager_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == 2'd3) |=> fault_o == 2'd0);

  // R4
  client_no_domfault_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == 2'd1) |=> fault_o != 2'd1);

  // R9
  section_code_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == 2'd1 && map_i == 3'd3) |=> fault_o != 2'd3);

  // R9
  page_code_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == 2'd1 && map_i != 3'd3) |=> fault_o != 2'd2);

  // R10
  last_dom_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> last_dom_o == $past(dom_i));
endmodule

bind dom_perm_check dom_perm_check_sva #(.DOM_W(DOM_W)) u_sva (
  .clk(clk), .rst(rst), .dom_i(dom_i), .map_i(map_i), .dacr_i(dacr_i),
  .fault_o(fault_o), .last_dom_o(last_dom_o)
);

// File: tb/sim_dom_perm_check.sv
module sim_dom_perm_check;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  dom_i = '0;
  logic [2:0]  map_i = '0;
  logic [11:0] perm_i = '0;
  logic [31:0] va_i = '0;
  logic        rd_i = 1'b0;
  logic [4:0]  mode_i = 5'h13;
  logic        sys_i = 1'b0;
  logic        rom_i = 1'b0;
  logic [31:0] dacr_i = '0;
  logic [1:0]  fault_o;
  logic [3:0]  last_dom_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dom_perm_check u0 (
    .clk(clk), .rst(rst), .dom_i(dom_i), .map_i(map_i), .perm_i(perm_i),
    .va_i(va_i), .rd_i(rd_i), .mode_i(mode_i), .sys_i(sys_i), .rom_i(rom_i),
    .dacr_i(dacr_i), .fault_o(fault_o), .last_dom_o(last_dom_o)
  );

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic bit allowed(input int ap, input bit rd, input bit unpriv,
                                 input bit s, input bit r);
    case (ap)
      0: return rd && ((s && !unpriv) || r);
      1: return !unpriv;
      2: return rd || !unpriv;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    int cnt;
    logic [4:0] modes [3];
    modes[0] = 5'h10; modes[1] = 5'h1F; modes[2] = 5'h13;
    cnt = 0;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 fault", int'(fault_o), 0);
    check("R1 last_dom", int'(last_dom_o), 0);
    rst = 1'b0;
    for (int mp = 0; mp < 6; mp++)
      for (int sp = 0; sp < 4; sp++)
        for (int ap = 0; ap < 4; ap++)
          for (int rd = 0; rd < 2; rd++)
            for (int md = 0; md < 3; md++)
              for (int sr = 0; sr < 4; sr++)
                for (int acc = 0; acc < 4; acc++) begin
                  int slot, expf, other_ap;
                  bit ok, unpriv;
                  logic [3:0] d;
                  d = 4'(cnt);
                  cnt++;
                  // R5 / R6 expected slot
                  case (mp)
                    1: slot = sp;
                    2: slot = 3 - sp;
                    3: slot = 3;
                    default: slot = 0;
                  endcase
                  unpriv = (md != 2);
                  ok = allowed(ap, rd[0], unpriv, sr[1], sr[0]);
                  // other slots use a code whose outcome differs when possible
                  other_ap = ok ? ((ap == 3) ? 0 : ap ^ 1) : 3;
                  if (ok && allowed(other_ap, rd[0], unpriv, sr[1], sr[0])) other_ap = 0;
                  perm_i = 12'(cnt & 15);
                  for (int k = 0; k < 4; k++)
                    perm_i[2*k+4 +: 2] = 2'((k == slot) ? ap : other_ap);
                  va_i = 32'h5A5A_0000 ^ 32'(cnt << 16);
                  va_i[15:14] = 2'(3 - sp);
                  va_i[11:10] = 2'(sp);
                  va_i[9:0] = 10'(cnt * 7);
                  for (int k = 0; k < 16; k++)
                    dacr_i[2*k +: 2] = 2'((k == int'(d)) ? acc : (acc + 1) % 4);
                  dom_i = d; map_i = 3'(mp); rd_i = rd[0];
                  mode_i = modes[md]; sys_i = sr[1]; rom_i = sr[0];
                  if (acc == 0 || acc == 2) expf = 1;
                  else if (acc == 3) expf = 0;
                  else if (ok) expf = 0;
                  else expf = (mp == 3) ? 2 : 3;
                  @(negedge clk);
                  if (acc != 1)
                    check((acc == 3) ? "R3 manager" : "R2 domain", int'(fault_o), expf);
                  else if (mp == 1 || mp == 2)
                    check("R5 R7 R8 R9 paged client", int'(fault_o), expf);
                  else
                    check("R4 R6 R7 R8 R9 fixed-slot client", int'(fault_o), expf);
                  check("R10 last_dom", int'(last_dom_o), int'(d));
                end
    // R1 reset again clears outputs
    rst = 1'b1;
    @(negedge clk);
    check("R1 fault after reset", int'(fault_o), 0);
    check("R1 last_dom after reset", int'(last_dom_o), 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule